// File: doc/BRIEF.md
# Head-of-Queue Read Selector for a Banked Shared-Buffer Switch

This block is the read side of a switch whose cell buffer is split across several independent memories. The write side hands it one queue entry per output port. Each entry names the memory that holds a stored cell and the cell's address in that memory. The selector keeps one first-in first-out address queue per output.

A cell slot is any clock cycle with `slotEn` high. In each slot the selector looks at the oldest entry of every non-empty queue. Two or more outputs may want the same memory in one slot. Each memory can serve at most `SPEEDUP` reads per slot, so when more outputs ask for it, a per-memory rotating pointer picks the winners. Every winner gets a registered crosspoint select (memory number plus address) on its port and is popped from its queue. A loser keeps its entry for a later slot.

One cycle after a read, the same memory and address appear on a release port so the write side can reuse the location. A write to a full queue is dropped and reported on a per-port error pulse.

Top module: `rs_read_selector`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rdValid`, `relValid` and `ovfErr` are all zero. Every address queue starts empty and every rotating pointer starts at port 0.
- R2: A slot is a rising edge with `slotEn` high. After that edge, each output whose oldest entry was granted shows `rdValid[p]`=1, with `rdMem`/`rdAddr` slice p holding that entry's memory number and address. When all oldest entries name distinct memories, every non-empty output is granted.
- R3: In one slot, no memory number appears on more than `SPEEDUP` asserted `rdValid` outputs.
- R4: Each memory has a rotating pointer. Requesters are granted in rising circular port order starting at the pointer, up to `SPEEDUP` of them. After a slot with at least one grant, the pointer moves to one past the last port granted.
- R5: A granted entry is removed from its queue, and a denied entry stays at the head for the next slot. Entries of one queue are served in the order they were written.
- R6: An output whose queue is empty, or whose head lost arbitration, has `rdValid[p]`=0 after that slot.
- R7: One cycle after `rdValid[p]` is asserted, `relValid[p]` is asserted, with `relMem`/`relAddr` slice p equal to the read's memory number and address.
- R8: Each queue holds `DEPTH` entries. A write into a full queue is discarded, and `ovfErr[p]` pulses high in the cycle after that write. Writes into a queue that is not full leave `ovfErr[p]` low.
- R9: A cycle with `slotEn` low grants nothing and removes nothing. All `rdValid` bits read 0 after it, and the queued heads are still served in a later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotEn | input | 1 | High marks this cycle as a cell slot |
| enqValid | input | NPORT | Per-output queue write strobe |
| enqMem | input | NPORT*MEMW | Memory number per written entry (port p at slice p) |
| enqAddr | input | NPORT*ADDRW | Cell address per written entry |
| rdValid | output | NPORT | Output granted in the last slot |
| rdMem | output | NPORT*MEMW | Crosspoint select: memory connected to each output |
| rdAddr | output | NPORT*ADDRW | Address read for each output |
| relValid | output | NPORT | Released-location strobe, one cycle after a read |
| relMem | output | NPORT*MEMW | Memory number of the released location |
| relAddr | output | NPORT*ADDRW | Address of the released location |
| ovfErr | output | NPORT | Write into a full queue was dropped |

## Verification
The assertions assume that every written memory number is below `NMEM`. A number outside that range would never be counted against any memory's read budget. The stimulus only writes memory numbers 0 to 7 with `NMEM` = 8.

The assertions also rely on `slotEn` and the write strobes being driven to known levels after reset. The bench drives every input on the falling clock edge from reset onward. It runs two copies of the block side by side with read budgets of one and two, so each collision pattern is checked against both limits.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int NPORT = 8;
  parameter int NMEM  = 8;
  parameter int ADDRW = 6;
  localparam int MEMW = $clog2(NMEM);
  localparam int PTRW = $clog2(NPORT);
  localparam int ENTW = MEMW + ADDRW;

  typedef struct packed {
    logic             slotFire;
    logic [NPORT-1:0] grant;
  } rsCtrl_t;
endpackage

// File: rtl/rs_addr_fifo.sv
module rs_addr_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doWr, doRd;

  assign full     = (count == CW'(DEPTH));
  assign notEmpty = (count != '0);
  assign doWr     = wrEn && !full;
  assign doRd     = rdEn && notEmpty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rsCtrl_t                ctrl,
  input  logic [NPORT-1:0]       enqValid,
  input  logic [NPORT*MEMW-1:0]  enqMem,
  input  logic [NPORT*ADDRW-1:0] enqAddr,
  output logic [NPORT-1:0]       notEmpty,
  output logic [NPORT*MEMW-1:0]  headMem,
  output logic [NPORT-1:0]       rdValid,
  output logic [NPORT*MEMW-1:0]  rdMem,
  output logic [NPORT*ADDRW-1:0] rdAddr,
  output logic [NPORT-1:0]       relValid,
  output logic [NPORT*MEMW-1:0]  relMem,
  output logic [NPORT*ADDRW-1:0] relAddr,
  output logic [NPORT-1:0]       ovfErr
);
  logic [NPORT-1:0]       fullVec;
  logic [NPORT-1:0]       popVec;
  logic [NPORT*ADDRW-1:0] headAddr;

  assign popVec = ctrl.slotFire ? ctrl.grant : '0;

  for (genvar p = 0; p < NPORT; p++) begin : g_queue
    logic [ENTW-1:0] head;
    rs_addr_fifo #(.DEPTH(DEPTH), .WIDTH(ENTW)) i_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .wrEn     (enqValid[p]),
      .wrData   ({enqMem[p*MEMW +: MEMW], enqAddr[p*ADDRW +: ADDRW]}),
      .rdEn     (popVec[p]),
      .headData (head),
      .notEmpty (notEmpty[p]),
      .full     (fullVec[p])
    );
    assign headMem[p*MEMW +: MEMW]    = head[ENTW-1 -: MEMW];
    assign headAddr[p*ADDRW +: ADDRW] = head[ADDRW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= '0;
      rdMem    <= '0;
      rdAddr   <= '0;
      relValid <= '0;
      relMem   <= '0;
      relAddr  <= '0;
      ovfErr   <= '0;
    end else begin
      rdValid  <= popVec;
      rdMem    <= headMem;
      rdAddr   <= headAddr;
      relValid <= rdValid;
      relMem   <= rdMem;
      relAddr  <= rdAddr;
      ovfErr   <= enqValid & fullVec;
    end
  end
endmodule

// File: rtl/rs_control.sv
module rs_control
  import rs_pkg::*;
#(
  parameter int SPEEDUP = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotEn,
  input  logic [NPORT-1:0]      notEmpty,
  input  logic [NPORT*MEMW-1:0] headMem,
  output rsCtrl_t               ctrl
);
  logic [PTRW-1:0]  rrPtr   [NMEM];
  logic [PTRW-1:0]  nextPtr [NMEM];
  logic [NPORT-1:0] grant;

  always_comb begin
    grant = '0;
    for (int m = 0; m < NMEM; m++) begin
      int served;
      served     = 0;
      nextPtr[m] = rrPtr[m];
      for (int k = 0; k < NPORT; k++) begin
        int p;
        p = (int'(rrPtr[m]) + k) % NPORT;
        if (notEmpty[p] && (headMem[p*MEMW +: MEMW] == MEMW'(m)) && (served < SPEEDUP)) begin
          grant[p]   = 1'b1;
          served     = served + 1;
          nextPtr[m] = PTRW'((p + 1) % NPORT);
        end
      end
    end
  end

  for (genvar m = 0; m < NMEM; m++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rstN)       rrPtr[m] <= '0;
      else if (slotEn) rrPtr[m] <= nextPtr[m];
    end
  end

  assign ctrl.slotFire = slotEn;
  assign ctrl.grant    = grant;
endmodule

// File: rtl/rs_read_selector.sv
module rs_read_selector
  import rs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SPEEDUP = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotEn,
  input  logic [NPORT-1:0]       enqValid,
  input  logic [NPORT*MEMW-1:0]  enqMem,
  input  logic [NPORT*ADDRW-1:0] enqAddr,
  output logic [NPORT-1:0]       rdValid,
  output logic [NPORT*MEMW-1:0]  rdMem,
  output logic [NPORT*ADDRW-1:0] rdAddr,
  output logic [NPORT-1:0]       relValid,
  output logic [NPORT*MEMW-1:0]  relMem,
  output logic [NPORT*ADDRW-1:0] relAddr,
  output logic [NPORT-1:0]       ovfErr
);
  rsCtrl_t               ctrl;
  logic [NPORT-1:0]      notEmpty;
  logic [NPORT*MEMW-1:0] headMem;

  rs_control #(.SPEEDUP(SPEEDUP)) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .slotEn   (slotEn),
    .notEmpty (notEmpty),
    .headMem  (headMem),
    .ctrl     (ctrl)
  );

  rs_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .enqValid (enqValid),
    .enqMem   (enqMem),
    .enqAddr  (enqAddr),
    .notEmpty (notEmpty),
    .headMem  (headMem),
    .rdValid  (rdValid),
    .rdMem    (rdMem),
    .rdAddr   (rdAddr),
    .relValid (relValid),
    .relMem   (relMem),
    .relAddr  (relAddr),
    .ovfErr   (ovfErr)
  );
endmodule

// File: rtl/rs_read_selector_chk.sv
module rs_read_selector_chk
  import rs_pkg::*;
#(
  parameter int SPEEDUP = 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   slotEn,
  input logic [NPORT-1:0]       enqValid,
  input logic [NPORT-1:0]       notEmpty,
  input logic [NPORT-1:0]       rdValid,
  input logic [NPORT*MEMW-1:0]  rdMem,
  input logic [NPORT*ADDRW-1:0] rdAddr,
  input logic [NPORT-1:0]       relValid,
  input logic [NPORT*MEMW-1:0]  relMem,
  input logic [NPORT*ADDRW-1:0] relAddr,
  input logic [NPORT-1:0]       ovfErr
);
  AST_VALID_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (|rdValid) |-> $past(slotEn)); // R9

  for (genvar m = 0; m < NMEM; m++) begin : g_mem
    logic [NPORT-1:0] hit;
    for (genvar p = 0; p < NPORT; p++) begin : g_hit
      assign hit[p] = rdValid[p] && (rdMem[p*MEMW +: MEMW] == MEMW'(m));
    end
    AST_SPEEDUP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      $countones(hit) <= SPEEDUP); // R3
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    AST_GRANT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
      rdValid[p] |-> $past(notEmpty[p])); // R6
    AST_RELEASE_DATA: assert property (@(posedge clk) disable iff (!rstN)
      relValid[p] |-> (relMem[p*MEMW +: MEMW] == $past(rdMem[p*MEMW +: MEMW]))
                   && (relAddr[p*ADDRW +: ADDRW] == $past(rdAddr[p*ADDRW +: ADDRW]))); // R7
    AST_OVF_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      ovfErr[p] |-> $past(enqValid[p])); // R8
  end
endmodule

bind rs_read_selector rs_read_selector_chk #(.SPEEDUP(SPEEDUP)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .slotEn   (slotEn),
  .enqValid (enqValid),
  .notEmpty (notEmpty),
  .rdValid  (rdValid),
  .rdMem    (rdMem),
  .rdAddr   (rdAddr),
  .relValid (relValid),
  .relMem   (relMem),
  .relAddr  (relAddr),
  .ovfErr   (ovfErr)
);

// File: tb/test_rs_read_selector.sv
module test_rs_read_selector;
  import rs_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   slotEn = 1'b0;
  logic [NPORT-1:0]       enqValid = '0;
  logic [NPORT*MEMW-1:0]  enqMem = '0;
  logic [NPORT*ADDRW-1:0] enqAddr = '0;
  logic [NPORT-1:0]       rdValid, relValid, ovfErr, rdValid2, relValid2, ovfErr2;
  logic [NPORT*MEMW-1:0]  rdMem, relMem, rdMem2, relMem2;
  logic [NPORT*ADDRW-1:0] rdAddr, relAddr, rdAddr2, relAddr2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rs_read_selector #(.DEPTH(16), .SPEEDUP(1)) i_rs_read_selector (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .enqValid(enqValid), .enqMem(enqMem),
    .enqAddr(enqAddr), .rdValid(rdValid), .rdMem(rdMem), .rdAddr(rdAddr),
    .relValid(relValid), .relMem(relMem), .relAddr(relAddr), .ovfErr(ovfErr));

  rs_read_selector #(.DEPTH(16), .SPEEDUP(2)) i_rs_read_selector_s2 (
    .clk(clk), .rstN(rstN), .slotEn(slotEn), .enqValid(enqValid), .enqMem(enqMem),
    .enqAddr(enqAddr), .rdValid(rdValid2), .rdMem(rdMem2), .rdAddr(rdAddr2),
    .relValid(relValid2), .relMem(relMem2), .relAddr(relAddr2), .ovfErr(ovfErr2));

  // Nibble p = port p's memory number; bit 3 set means the port gets no entry.
  typedef struct packed {
    logic [31:0] memCodes;
    logic [7:0]  expS1;
    logic [7:0]  expS2;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h76543210, 8'hFF, 8'hFF},
    '{32'h33333333, 8'h01, 8'h03},
    '{32'h88488488, 8'h04, 8'h24},
    '{32'h88888888, 8'h00, 8'h00},
    '{32'h07811100, 8'h45, 8'h4F},
    '{32'h22288888, 8'h20, 8'h60}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; slotEn = 1'b0; enqValid = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic enqOne(input int p, input int mem, input int addr);
    @(negedge clk);
    enqValid = '0;
    enqValid[p] = 1'b1;
    enqMem[p*MEMW +: MEMW] = MEMW'(mem);
    enqAddr[p*ADDRW +: ADDRW] = ADDRW'(addr);
    @(posedge clk);
    @(negedge clk);
    enqValid = '0;
  endtask

  // Fires one slot; the results are sampled at the negedge after the slot edge.
  task automatic oneSlot();
    @(negedge clk);
    slotEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    slotEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rdValid in reset", 32'(rdValid), 0);
    check("R1 relValid in reset", 32'(relValid), 0);
    check("R1 ovfErr in reset", 32'(ovfErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdValid after release", 32'(rdValid | rdValid2), 0);

    // Table of collision patterns: R2 R3 R4 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      enqValid = '0;
      for (int p = 0; p < NPORT; p++) begin
        logic [3:0] code;
        code = VECS[v].memCodes[p*4 +: 4];
        enqValid[p] = !code[3];
        enqMem[p*MEMW +: MEMW] = MEMW'(code[2:0]);
        enqAddr[p*ADDRW +: ADDRW] = ADDRW'(p + 8 * v);
      end
      @(posedge clk);
      @(negedge clk);
      enqValid = '0;
      oneSlot();
      check($sformatf("R3 R4 R6 vec%0d mask speedup1", v), 32'(rdValid), 32'(VECS[v].expS1));
      check($sformatf("R3 R4 vec%0d mask speedup2", v), 32'(rdValid2), 32'(VECS[v].expS2));
      for (int p = 0; p < NPORT; p++) begin
        if (VECS[v].expS1[p]) begin
          check($sformatf("R2 vec%0d port%0d mem", v, p), 32'(rdMem[p*MEMW +: MEMW]),
                32'(VECS[v].memCodes[p*4 +: 3]));
          check($sformatf("R2 vec%0d port%0d addr", v, p), 32'(rdAddr[p*ADDRW +: ADDRW]), 32'(p + 8 * v));
        end
      end
      @(negedge clk);
      check($sformatf("R7 vec%0d release mask", v), 32'(relValid), 32'(VECS[v].expS1));
      for (int p = 0; p < NPORT; p++) begin
        if (VECS[v].expS1[p]) begin
          check($sformatf("R7 vec%0d port%0d release addr", v, p), 32'(relAddr[p*ADDRW +: ADDRW]), 32'(p + 8 * v));
          check($sformatf("R7 vec%0d port%0d release mem", v, p), 32'(relMem[p*MEMW +: MEMW]),
                32'(VECS[v].memCodes[p*4 +: 3]));
        end
      end
    end

    // R4 R5: rotating pointer and losers keeping their head
    doReset();
    enqOne(1, 3, 10);
    enqOne(1, 3, 11);
    enqOne(4, 3, 20);
    oneSlot();
    check("R4 slot1 grant", 32'(rdValid), 32'h02);
    check("R5 slot1 addr port1", 32'(rdAddr[1*ADDRW +: ADDRW]), 10);
    check("R3 slot1 speedup2 both", 32'(rdValid2), 32'h12);
    oneSlot();
    check("R4 slot2 pointer moved to port4", 32'(rdValid), 32'h10);
    check("R5 slot2 loser served addr", 32'(rdAddr[4*ADDRW +: ADDRW]), 20);
    oneSlot();
    check("R5 slot3 second entry port1", 32'(rdValid), 32'h02);
    check("R5 slot3 addr port1", 32'(rdAddr[1*ADDRW +: ADDRW]), 11);
    oneSlot();
    check("R6 queues drained", 32'(rdValid), 0);

    // R9: idle cycles serve and remove nothing
    doReset();
    enqOne(3, 2, 7);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 no slot no valid", 32'(rdValid), 0);
    end
    oneSlot();
    check("R9 head kept through idle", 32'(rdValid), 32'h08);
    check("R9 head addr", 32'(rdAddr[3*ADDRW +: ADDRW]), 7);

    // R8 R5: fill, overflow, ordered drain
    doReset();
    for (int i = 0; i < 16; i++) enqOne(0, 5, i);
    check("R8 no error below full", 32'(ovfErr), 0);
    @(negedge clk);
    enqValid[0] = 1'b1;
    enqMem[0 +: MEMW] = MEMW'(5);
    enqAddr[0 +: ADDRW] = ADDRW'(63);
    @(posedge clk);
    @(negedge clk);
    enqValid = '0;
    check("R8 overflow pulse", 32'(ovfErr), 32'h01);
    @(negedge clk);
    check("R8 overflow is a pulse", 32'(ovfErr), 0);
    slotEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R5 drain %0d valid", i), 32'(rdValid), 32'h01);
      check($sformatf("R5 drain %0d order", i), 32'(rdAddr[0 +: ADDRW]), i);
    end
    @(posedge clk);
    @(negedge clk);
    slotEn = 1'b0;
    check("R8 dropped write never served", 32'(rdValid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule